// File: doc/BRIEF.md
# Serial Memory Page-Write and Streaming-Read Engine

This block is the burst data path of a three-wire serial memory slave organised as bytes. Once a separate command decoder has recognised an operation and its start address, it hands this engine a one-cycle command pulse. The engine then takes over the serial lines. For a page write, it gathers complete bytes from the data input into a small page buffer. The buffer pointer wraps inside a 16-byte page, and nothing reaches the array until chip select drops. For a streaming read, it shifts bytes out on the data output for as long as chip select stays high. The read address walks through the whole array and wraps at the top.

All serial inputs (chip select, serial clock, data in) are treated as synchronous to the system clock `clk`, and a serial clock rising edge is detected by comparing successive samples. The array sits outside the block. Writes reach it through a registered strobe, address and data. Reads use an address output and a data input that must be valid one clock after the address changes. The busy timing and command decoding belong to a neighbouring block, and that block keeps chip select low while a commit is running.

Top module: `mw_burst_engine`

## Requirements
- R1: After reset, `arr_we`, `do_oe` and `do_out` are all 0.
- R2: A page-write command (`cmd_op` = 2'b10) is accepted only if `wr_enable` is 1 in the cycle of `cmd_valid`. Otherwise no array write strobe follows the transfer.
- R3: After an accepted page-write command, each group of 8 serial clock rising edges forms one byte from `di`, most significant bit first. The byte is stored at the current pointer, and the pointer then advances by one.
- R4: The pointer advance affects only the low 4 address bits, so offset 15 is followed by offset 0. The upper 5 address bits stay those of the start address.
- R5: While chip select is high, no array write happens. After chip select falls, each buffered location is written once, in ascending page offset, and all writes finish within 18 clocks of the fall.
- R6: If more than 16 bytes arrive in one page write, a later byte replaces the buffered byte at the same wrapped offset. Each location is written only once, with its final value.
- R7: Bits of a byte left incomplete when chip select falls are discarded. Only complete bytes are written.
- R8: A read command (`cmd_op` = 2'b01) drives `do_oe` high with `do_out` = 0 as a dummy bit until the first serial clock rise. After that, data bits appear most significant first, and `do_out` changes only after a serial clock rising edge.
- R9: With chip select still high, the byte at the next higher address follows each completed byte. Address 511 is followed by address 0.
- R10: `do_oe` is low whenever chip select is low. After chip select falls, serial clocks without a new command produce no output and no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high while a transfer is framed |
| sk | input | 1 | Serial clock, sampled on `clk` |
| di | input | 1 | Serial data in |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is presented |
| cmd_op | input | 2 | Decoded operation: 2'b01 read, 2'b10 page write |
| cmd_addr | input | 9 | Start address of the decoded command |
| wr_enable | input | 1 | Write-enable state held by the decoder |
| rd_data | input | 8 | Array read data, valid one clock after `rd_addr` |
| rd_addr | output | 9 | Array read address |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 9 | Array write address |
| arr_wdata | output | 8 | Array write data |
| do_out | output | 1 | Serial data out |
| do_oe | output | 1 | Output enable of `do_out`; low means high impedance |

## Verification
The bench uses the default parameters: a 9-bit address, 8-bit data and a 16-byte page. With these values a 20-byte burst overruns a page and overwrites four entries. A read that starts at address 511 crosses the top of the 512-byte array after a single byte. A page write that starts at offset 14 wraps after two bytes. The bench also covers a write with writing disabled, a byte cut short by chip select, and serial clocks sent with no command, and it compares every outcome against its own model of the array.

// File: rtl/mw_burst_pkg.sv
// Shared definitions for the serial burst engine.
// Assumes the command decoder uses exactly these operation codes.
package mw_burst_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'b00,
        OP_READ    = 2'b01,
        OP_PAGE_WR = 2'b10
    } burst_op_e;

endpackage

// File: rtl/mw_edge_detect.sv
// Edge detector for the framing inputs.
// Assumes sk and cs are already synchronous to clk. Produces single-cycle
// pulses on a serial clock rise and on a chip select fall.
module mw_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_fall
);

    logic sk_q;
    logic cs_q;

    // Purpose: keep the previous sample of both framing inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q;
    assign cs_fall = ~cs & cs_q;

endmodule

// File: rtl/mw_page_collector.sv
// Page-write collector and commit sequencer.
// Gathers complete bytes into a page buffer indexed by the low PAGE_W address
// bits. On a chip select fall it writes every filled entry to the array, one
// per clock, in ascending offset. Assumes chip select stays low for the whole
// commit, which the neighbouring busy logic guarantees.
module mw_page_collector #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              cs_fall,
    input  logic              di,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_enable,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int DEPTH   = 1 << PAGE_W;
    localparam int UPPER_W = ADDR_W - PAGE_W;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [PAGE_W-1:0] LAST_IDX = {PAGE_W{1'b1}};

    logic                collecting_q;
    logic [UPPER_W-1:0]  upper_q;
    logic [PAGE_W-1:0]   ptr_q;
    logic [CNT_W-1:0]    bitcnt_q;
    logic [DATA_W-1:0]   shift_q;
    logic                committing_q;
    logic [PAGE_W-1:0]   idx_q;
    logic [DEPTH-1:0]    filled_q;
    logic [DATA_W-1:0]   page_mem [DEPTH];
    logic [DEPTH-1:0]    slot_hit;
    logic [DEPTH-1:0]    slot_drain;
    logic                byte_done;
    logic [DATA_W-1:0]   new_byte;

    assign new_byte  = {shift_q[DATA_W-2:0], di};
    assign byte_done = collecting_q && cs && sk_rise && (bitcnt_q == LAST_BIT);

    // Per-entry decode of the store and drain selects.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_hit[g]   = byte_done && (ptr_q == PAGE_W'(g));
        assign slot_drain[g] = committing_q && (idx_q == PAGE_W'(g));
    end

    // Purpose: track the collect phase, bit count, shifter and page pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting_q <= 1'b0;
            upper_q      <= '0;
            ptr_q        <= '0;
            bitcnt_q     <= '0;
            shift_q      <= '0;
        end else if (start) begin
            collecting_q <= wr_enable;
            upper_q      <= start_addr[ADDR_W-1:PAGE_W];
            ptr_q        <= start_addr[PAGE_W-1:0];
            bitcnt_q     <= '0;
        end else if (cs_fall) begin
            collecting_q <= 1'b0;
            bitcnt_q     <= '0;
        end else if (collecting_q && sk_rise) begin
            shift_q <= new_byte;
            if (bitcnt_q == LAST_BIT) begin
                bitcnt_q <= '0;
                ptr_q    <= ptr_q + 1'b1;
            end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    // Purpose: hold buffered bytes and their filled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                page_mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (start) begin
                    filled_q[i] <= 1'b0;
                end else if (slot_hit[i]) begin
                    filled_q[i] <= 1'b1;
                    page_mem[i] <= new_byte;
                end else if (slot_drain[i]) begin
                    filled_q[i] <= 1'b0;
                end
            end
        end
    end

    // Purpose: step through all page offsets once after chip select falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committing_q <= 1'b0;
            idx_q        <= '0;
        end else if (cs_fall && collecting_q) begin
            committing_q <= 1'b1;
            idx_q        <= '0;
        end else if (committing_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) begin
                committing_q <= 1'b0;
            end
        end
    end

    // Purpose: register the array write strobe, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we    <= 1'b0;
            arr_waddr <= '0;
            arr_wdata <= '0;
        end else begin
            arr_we    <= committing_q && filled_q[idx_q];
            arr_waddr <= {upper_q, idx_q};
            arr_wdata <= page_mem[idx_q];
        end
    end

endmodule

// File: rtl/mw_stream_reader.sv
// Streaming read shifter.
// After a read command it drives a dummy 0. On every serial clock rise it
// then presents the next bit, most significant first. A fresh byte is
// loaded from rd_data each time a byte boundary is reached, and the address
// advances across the full array. Assumes rd_data is valid one clock after
// rd_addr changes and that serial clock rises are at least two clocks apart.
module mw_stream_reader #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              do_bit,
    output logic              active
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bitcnt_q;
    logic [DATA_W-2:0] shift_q;

    // Purpose: run the read stream while chip select stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            rd_addr  <= '0;
            bitcnt_q <= '0;
            shift_q  <= '0;
            do_bit   <= 1'b0;
        end else if (!cs) begin
            active   <= 1'b0;
            bitcnt_q <= '0;
            do_bit   <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            rd_addr  <= start_addr;
            bitcnt_q <= '0;
            do_bit   <= 1'b0;
        end else if (active && sk_rise) begin
            if (bitcnt_q == '0) begin
                do_bit  <= rd_data[DATA_W-1];
                shift_q <= rd_data[DATA_W-2:0];
                rd_addr <= rd_addr + 1'b1;
            end else begin
                do_bit  <= shift_q[DATA_W-2];
                shift_q <= {shift_q[DATA_W-3:0], 1'b0};
            end
            bitcnt_q <= (bitcnt_q == LAST_BIT) ? '0 : bitcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mw_burst_engine.sv
// Top of the burst data path for a byte-organised serial memory slave.
// Routes a decoded command to the page collector or the stream reader and
// drives the serial output enable. Assumes cmd_valid is raised only while
// chip select is high and never during a commit.
module mw_burst_engine
    import mw_burst_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wr_enable,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              do_out,
    output logic              do_oe
);

    logic sk_rise;
    logic cs_fall;
    logic wr_start;
    logic rd_start;
    logic rd_active;

    assign wr_start = cmd_valid && cs && (cmd_op == OP_PAGE_WR);
    assign rd_start = cmd_valid && cs && (cmd_op == OP_READ);

    mw_edge_detect i_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .cs      (cs),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    mw_page_collector #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) i_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sk_rise    (sk_rise),
        .cs_fall    (cs_fall),
        .di         (di),
        .start      (wr_start),
        .start_addr (cmd_addr),
        .wr_enable  (wr_enable),
        .arr_we     (arr_we),
        .arr_waddr  (arr_waddr),
        .arr_wdata  (arr_wdata)
    );

    mw_stream_reader #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sk_rise    (sk_rise),
        .start      (rd_start),
        .start_addr (cmd_addr),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .do_bit     (do_out),
        .active     (rd_active)
    );

    assign do_oe = cs && rd_active;

endmodule

// File: rtl/mw_burst_checker.sv
// Protocol checker for mw_burst_engine, attached through bind.
module mw_burst_checker
    import mw_burst_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              sk,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              do_out,
    input logic              do_oe,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr
);

    // R1: outputs quiet during reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!arr_we && !do_oe));

    // R5: no array write while chip select is high
    p_no_write_cs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !cs);

    // R6 and R4: back-to-back writes ascend in offset inside one page
    p_commit_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            ((arr_waddr[PAGE_W-1:0] > $past(arr_waddr[PAGE_W-1:0])) &&
             (arr_waddr[ADDR_W-1:PAGE_W] == $past(arr_waddr[ADDR_W-1:PAGE_W]))));

    // R8: dummy zero right after a read command
    p_dummy_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cs && (cmd_op == OP_READ)) |=> (do_oe && !do_out));

    // R8: data out moves only after a serial clock rise or a new command
    p_do_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && $past(do_oe) && !($past(sk) && !$past(sk, 2)) && !$past(cmd_valid))
            |-> $stable(do_out));

    // R10: output enable only rises after a command
    p_oe_needs_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe) |-> $past(cmd_valid));

endmodule

bind mw_burst_engine mw_burst_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) i_burst_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .sk        (sk),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .do_out    (do_out),
    .do_oe     (do_oe),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr)
);

// File: tb/test_mw_burst_engine.sv
`timescale 1ns/1ps
module test_mw_burst_engine;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 4;
    localparam int MEM    = 1 << ADDR_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              wr_enable = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_wdata;
    logic              do_out, do_oe;

    logic [DATA_W-1:0] dut_mem [MEM];
    logic [DATA_W-1:0] ref_mem [MEM];
    int checks = 0, fails = 0, we_count = 0, clk_errs = 0;
    bit done = 0;

    mw_burst_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_mw_burst_engine (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .wr_enable(wr_enable), .rd_data(rd_data), .rd_addr(rd_addr),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .do_out(do_out), .do_oe(do_oe)
    );

    assign rd_data = dut_mem[rd_addr];

    // Behavioural array plus per-clock comparison of framing rules.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM; i++) dut_mem[i] = 8'(i * 7 + 3);
        end else begin
            if (arr_we) begin
                dut_mem[arr_waddr] = arr_wdata;
                we_count++;
            end
            if (arr_we && cs) clk_errs++;   // R5
            if (!cs && do_oe) clk_errs++;   // R10
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input bit b, output bit d);
        @(negedge clk); di = b; sk = 1'b1;
        @(negedge clk); d = do_out; sk = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input int a);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a);
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < MEM; i++) if (dut_mem[i] !== ref_mem[i]) n++;
        return n;
    endfunction

    task automatic page_write(input int a, input bit wen, input logic [7:0] data[$],
                              input int extra, input string req);
        int pend[int];
        int p;
        int n;
        bit d;
        we_count = 0;
        @(negedge clk); cs = 1'b1; wr_enable = wen;
        issue(2'b10, a);
        foreach (data[k]) for (int b = 7; b >= 0; b--) sk_bit(data[k][b], d);
        for (int b = 0; b < extra; b++) sk_bit(1'b1, d);
        @(negedge clk); cs = 1'b0;
        repeat (20) @(negedge clk);
        p = a & 15;
        foreach (data[k]) begin
            pend[(a & 'h1F0) | p] = data[k];
            p = (p + 1) & 15;
        end
        if (wen) foreach (pend[k]) ref_mem[k] = pend[k];
        n = wen ? pend.num() : 0;
        check(we_count == n, {req, " strobe count"}, we_count, n);
        check(mem_diff() == 0, {req, " array contents"}, mem_diff(), 0);
    endtask

    task automatic stream_read(input int a, input int nbytes, input string req);
        int mism = 0;
        int ad = a;
        bit d;
        @(negedge clk); cs = 1'b1;
        issue(2'b01, a);
        check(do_oe === 1'b1 && do_out === 1'b0, "R8 dummy bit", {do_oe, do_out}, 2);
        for (int n = 0; n < nbytes; n++) begin
            for (int b = 7; b >= 0; b--) begin
                sk_bit(1'b0, d);
                if (d !== ref_mem[ad][b]) mism++;
            end
            ad = (ad + 1) % MEM;
        end
        check(mism == 0, req, mism, 0);
        @(negedge clk); cs = 1'b0;
        @(negedge clk);
        check(do_oe === 1'b0, "R10 oe after cs low", do_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] q[$];
        bit d;
        for (int i = 0; i < MEM; i++) ref_mem[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        check(arr_we === 1'b0 && do_oe === 1'b0 && do_out === 1'b0, "R1 reset state",
              {arr_we, do_oe, do_out}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: writing disabled
        page_write('h040, 1'b0, '{8'h11, 8'h22, 8'h33}, 0, "R2 write disabled");
        // R3 and R5: plain page write
        page_write('h123, 1'b1, '{8'hA5, 8'h3C, 8'hF0}, 0, "R3 R5 page write");
        // R4: wrap inside the page
        page_write('h1AE, 1'b1, '{8'h01, 8'h82, 8'h43, 8'hC4}, 0, "R4 page wrap");
        // R6: more than a page of bytes
        q = {};
        for (int k = 0; k < 20; k++) q.push_back(8'(8'h10 + k));
        page_write('h050, 1'b1, q, 0, "R6 page overrun");
        // R7: trailing partial byte
        page_write('h070, 1'b1, '{8'h9E, 8'h6B}, 5, "R7 partial byte");

        // R8 and R9: reads, including across the top of the array
        stream_read('h123, 2, "R8 read data");
        stream_read('h1FF, 3, "R9 address wrap");
        stream_read('h050, 17, "R9 long stream");

        // R10: serial clocks with no command
        we_count = 0;
        begin
            int oe_seen = 0;
            @(negedge clk); cs = 1'b1;
            for (int b = 0; b < 8; b++) begin
                sk_bit(1'b1, d);
                if (do_oe !== 1'b0) oe_seen++;
            end
            @(negedge clk); cs = 1'b0;
            repeat (20) @(negedge clk);
            check(oe_seen == 0, "R10 no output without command", oe_seen, 0);
            check(we_count == 0 && mem_diff() == 0, "R10 no write without command", we_count, 0);
        end

        check(clk_errs == 0, "R5/R10 per-clock framing", clk_errs, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule